// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a watchdog timer behind a simple word-addressed register bus. An up-counter starts from a programmed load value and advances on a slow tick enable (nominally 32 kHz, delivered as a single-cycle pulse in the system clock domain). An optional power-of-two prescaler slows it further. If software does not refresh the counter before it passes its all-ones value, the block raises a one-cycle reset request and restarts the count from the load value.

Software cannot start or stop the count with a single write. It has to write a pair of key words in the right order to the run-control register. The counter is refreshed by writing a trigger word that differs from the previous one. Writes to the control, load, trigger and run-control registers are posted. Each one stays in a holding slot for a fixed number of clock cycles before it takes effect. While a write is held, its own pending flag in the status register is set, so software can poll the flag before issuing the next write.

Top module: `kwdt_top`

## Requirements
- R1: After reset the counter reads 0 and is stopped, the control, load, system-config and status registers read 0, and `rst_req_o` is low.
- R2: Writing a run-control word whose low 16 bits are 0xBBBB, and then one whose low 16 bits are 0x4444, starts the counter.
- R3: Writing a run-control word whose low 16 bits are 0xAAAA, and then one whose low 16 bits are 0x5555, stops the counter.
- R4: If the run-control write that follows a first key is not the matching second key, the key sequence returns to its start and the run state does not change.
- R5: Status bit 0 flags a pending control write, bit 2 a pending load write, bit 3 a pending trigger write and bit 4 a pending run-control write. Each flag reads 1 in exactly PEND_CYC consecutive status reads, starting with the read presented in the cycle after the write, and then reads 0. The write takes effect when its flag clears.
- R6: Control bit 5 enables the prescaler and bits 4:2 hold its exponent p. With the prescaler enabled the counter advances once every 2^p ticks. With it disabled the counter advances on every tick.
- R7: A trigger write reloads the counter from the load register only if its 32-bit value differs from the last trigger value that took effect. The trigger value is 0 after reset. Repeating the same value has no effect.
- R8: While running, the counter counts up by one on each advance. While stopped, it holds its value.
- R9: An advance taken at the all-ones count reloads the load value and raises `rst_req_o` for exactly one clock cycle.
- R10: While the counter runs, writes to the control and load registers are dropped. They raise no pending flag and leave the readback unchanged.
- R11: The system-config register stores only bit 0 of the written word and returns it on read.
- R12: The word addresses are: 0 control, 1 system config, 2 status, 3 load, 4 trigger, 5 run control (reads 0), 6 current count. `bus_rdata` returns the addressed register one clock cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Single-cycle slow-tick enable |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 32 | Registered read data |
| rst_req_o | output | 1 | One-cycle reset request on counter wrap |

## Verification
The bench builds the block with a 12-bit counter and a four-cycle posting delay. With a 12-bit counter, a wrap is only a few ticks away from any load value near the top of the range. The bench sweeps sixteen load offsets below all-ones with the prescaler off, and all eight prescaler exponents with the prescaler on, checking that the reset request appears on exactly the computed tick. It also walks each posted register's pending flag cycle by cycle, and drives the key sequences through both valid and broken orders.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  // Register word addresses
  localparam int ADR_CTRL   = 0;
  localparam int ADR_SYSCFG = 1;
  localparam int ADR_STATUS = 2;
  localparam int ADR_LOAD   = 3;
  localparam int ADR_TRIG   = 4;
  localparam int ADR_KEY    = 5;
  localparam int ADR_COUNT  = 6;

  // Status bit positions
  localparam int ST_CTRL = 0;
  localparam int ST_LOAD = 2;
  localparam int ST_TRIG = 3;
  localparam int ST_KEY  = 4;

  // Key words
  localparam logic [15:0] KEY_ON_A  = 16'hBBBB;
  localparam logic [15:0] KEY_ON_B  = 16'h4444;
  localparam logic [15:0] KEY_OFF_A = 16'hAAAA;
  localparam logic [15:0] KEY_OFF_B = 16'h5555;

  localparam int PTV_W = 3;

  typedef enum logic [1:0] {
    KS_IDLE    = 2'd0,
    KS_ARM_ON  = 2'd1,
    KS_ARM_OFF = 2'd2
  } key_state_t;
endpackage

// File: rtl/kwdt_post.sv
module kwdt_post #(
  parameter int W        = 16,
  parameter int PEND_CYC = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_i,
  input  logic [W-1:0] data_i,
  output logic         busy_o,
  output logic         commit_o,
  output logic [W-1:0] data_o
);
  localparam int CW = $clog2(PEND_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      data_q <= '0;
    end else if (wr_i) begin
      cnt_q  <= CW'(PEND_CYC);
      data_q <= data_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o   = (cnt_q != '0);
  assign commit_o = (cnt_q == CW'(1)) && !wr_i;
  assign data_o   = data_q;

  // R5: a held write clears its flag right after it commits
  a_r5_commit_clears: assert property (@(posedge clk) disable iff (rst)
    commit_o |=> !busy_o);
  // R5: a flag only rises after a write strobe
  a_r5_busy_from_write: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(wr_i));
endmodule

// File: rtl/kwdt_keyseq.sv
module kwdt_keyseq
  import kwdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        commit_i,
  input  logic [15:0] key_i,
  output logic        run_o
);
  key_state_t st_q;
  logic       run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= KS_IDLE;
      run_q <= 1'b0;
    end else if (commit_i) begin
      case (st_q)
        KS_IDLE: begin
          if (key_i == KEY_ON_A)       st_q <= KS_ARM_ON;
          else if (key_i == KEY_OFF_A) st_q <= KS_ARM_OFF;
          else                         st_q <= KS_IDLE;
        end
        KS_ARM_ON: begin
          if (key_i == KEY_ON_B) run_q <= 1'b1;
          st_q <= KS_IDLE;
        end
        KS_ARM_OFF: begin
          if (key_i == KEY_OFF_B) run_q <= 1'b0;
          st_q <= KS_IDLE;
        end
        default: st_q <= KS_IDLE;
      endcase
    end
  end

  assign run_o = run_q;

  // R4: the run state moves only when a run-control write commits
  a_r4_run_needs_key: assert property (@(posedge clk) disable iff (rst)
    !commit_i |=> $stable(run_o));
  // R2: a start is always preceded by the armed state
  a_r2_start_armed: assert property (@(posedge clk) disable iff (rst)
    $rose(run_o) |-> $past(st_q == KS_ARM_ON));
  // R3: a stop is always preceded by the armed-off state
  a_r3_stop_armed: assert property (@(posedge clk) disable iff (rst)
    $fell(run_o) |-> $past(st_q == KS_ARM_OFF));
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
  import kwdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             pre_en_i,
  input  logic [PTV_W-1:0] ptv_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam int PCNT_W = (1 << PTV_W) - 1;

  logic [CNT_W-1:0]  cnt_q;
  logic [PCNT_W-1:0] pcnt_q;
  logic [PCNT_W-1:0] plimit;
  logic              step;
  logic              wrap_q;

  assign plimit = (PCNT_W'(1) << ptv_i) - PCNT_W'(1);
  assign step   = run_i && tick_i && (!pre_en_i || (pcnt_q == plimit));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      pcnt_q <= '0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= 1'b0;
      if (reload_i) begin
        cnt_q  <= load_i;
        pcnt_q <= '0;
      end else if (!run_i) begin
        pcnt_q <= '0;
      end else if (tick_i) begin
        if (pre_en_i && (pcnt_q != plimit)) pcnt_q <= pcnt_q + 1'b1;
        else                                 pcnt_q <= '0;
        if (step) begin
          if (cnt_q == '1) begin
            cnt_q  <= load_i;
            wrap_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = wrap_q;

  // R9: a wrap leaves the counter at the load value
  a_r9_wrap_reloads: assert property (@(posedge clk) disable iff (rst)
    wrap_o |-> (cnt_o == $past(load_i)));
  // R9: a wrap only follows a running tick
  a_r9_wrap_on_tick: assert property (@(posedge clk) disable iff (rst)
    wrap_o |-> $past(run_i && tick_i));
  // R8: a stopped counter without reload holds
  a_r8_hold_stopped: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !reload_i) |=> $stable(cnt_o));
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int PEND_CYC = 4,
  parameter int ADDR_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  output logic              rst_req_o
);
  localparam int CTRL_W = PTV_W + 1;
  localparam int TRIG_W = 32;

  logic running;

  logic sel_ctrl, sel_sys, sel_load, sel_trig, sel_key;
  assign sel_ctrl = bus_we && (bus_addr == ADDR_W'(ADR_CTRL));
  assign sel_sys  = bus_we && (bus_addr == ADDR_W'(ADR_SYSCFG));
  assign sel_load = bus_we && (bus_addr == ADDR_W'(ADR_LOAD));
  assign sel_trig = bus_we && (bus_addr == ADDR_W'(ADR_TRIG));
  assign sel_key  = bus_we && (bus_addr == ADDR_W'(ADR_KEY));

  // Posted slots
  logic              ctrl_busy, ctrl_commit;
  logic [CTRL_W-1:0] ctrl_post;
  logic              load_busy, load_commit;
  logic [CNT_W-1:0]  load_post;
  logic              trig_busy, trig_commit;
  logic [TRIG_W-1:0] trig_post;
  logic              key_busy, key_commit;
  logic [15:0]       key_post;

  kwdt_post #(.W(CTRL_W), .PEND_CYC(PEND_CYC)) u_post_ctrl (
    .clk(clk), .rst(rst), .wr_i(sel_ctrl && !running),
    .data_i({bus_wdata[5], bus_wdata[4:2]}),
    .busy_o(ctrl_busy), .commit_o(ctrl_commit), .data_o(ctrl_post));

  kwdt_post #(.W(CNT_W), .PEND_CYC(PEND_CYC)) u_post_load (
    .clk(clk), .rst(rst), .wr_i(sel_load && !running),
    .data_i(bus_wdata[CNT_W-1:0]),
    .busy_o(load_busy), .commit_o(load_commit), .data_o(load_post));

  kwdt_post #(.W(TRIG_W), .PEND_CYC(PEND_CYC)) u_post_trig (
    .clk(clk), .rst(rst), .wr_i(sel_trig),
    .data_i(bus_wdata),
    .busy_o(trig_busy), .commit_o(trig_commit), .data_o(trig_post));

  kwdt_post #(.W(16), .PEND_CYC(PEND_CYC)) u_post_key (
    .clk(clk), .rst(rst), .wr_i(sel_key),
    .data_i(bus_wdata[15:0]),
    .busy_o(key_busy), .commit_o(key_commit), .data_o(key_post));

  // Architectural registers
  logic              pre_en_q;
  logic [PTV_W-1:0]  ptv_q;
  logic [CNT_W-1:0]  load_q;
  logic [TRIG_W-1:0] last_trig_q;
  logic              sys_q;
  logic              reload;

  assign reload = trig_commit && (trig_post != last_trig_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_en_q    <= 1'b0;
      ptv_q       <= '0;
      load_q      <= '0;
      last_trig_q <= '0;
      sys_q       <= 1'b0;
    end else begin
      if (ctrl_commit && !running) {pre_en_q, ptv_q} <= ctrl_post;
      if (load_commit && !running) load_q <= load_post;
      if (reload)                  last_trig_q <= trig_post;
      if (sel_sys)                 sys_q <= bus_wdata[0];
    end
  end

  kwdt_keyseq u_keys (
    .clk(clk), .rst(rst), .commit_i(key_commit), .key_i(key_post),
    .run_o(running));

  logic [CNT_W-1:0] cnt;
  logic             wrap;

  kwdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run_i(running), .tick_i(tick_i),
    .pre_en_i(pre_en_q), .ptv_i(ptv_q), .reload_i(reload),
    .load_i(load_q), .cnt_o(cnt), .wrap_o(wrap));

  assign rst_req_o = wrap;

  // Registered read path
  logic [31:0] status_w;
  always_comb begin
    status_w          = '0;
    status_w[ST_CTRL] = ctrl_busy;
    status_w[ST_LOAD] = load_busy;
    status_w[ST_TRIG] = trig_busy;
    status_w[ST_KEY]  = key_busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        ADDR_W'(ADR_CTRL):   bus_rdata <= {26'd0, pre_en_q, ptv_q, 2'b00};
        ADDR_W'(ADR_SYSCFG): bus_rdata <= {31'd0, sys_q};
        ADDR_W'(ADR_STATUS): bus_rdata <= status_w;
        ADDR_W'(ADR_LOAD):   bus_rdata <= 32'(load_q);
        ADDR_W'(ADR_TRIG):   bus_rdata <= last_trig_q;
        ADDR_W'(ADR_COUNT):  bus_rdata <= 32'(cnt);
        default:             bus_rdata <= '0;
      endcase
    end
  end

  // R10: control settings are frozen while running
  a_r10_ctrl_frozen: assert property (@(posedge clk) disable iff (rst)
    $past(running) && running |-> $stable({pre_en_q, ptv_q}));
  // R10: the load value is frozen while running
  a_r10_load_frozen: assert property (@(posedge clk) disable iff (rst)
    $past(running) && running |-> $stable(load_q));
  // R7: repeating the trigger word never reloads
  a_r7_same_trig: assert property (@(posedge clk) disable iff (rst)
    (trig_commit && (trig_post == last_trig_q)) |=> $stable(last_trig_q));
  // R9: the reset request never lasts two cycles without a second tick
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (rst_req_o && !tick_i) |=> !rst_req_o);
endmodule

// File: tb/kwdt_top_test.sv
module kwdt_top_test;
  localparam int CNT_W    = 12;
  localparam int PEND_CYC = 4;
  localparam int ADDR_W   = 3;
  localparam int MAXV     = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              tick = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic              we = 1'b0;
  logic [31:0]       rdata;
  logic              rst_req;

  int n_tests = 0;
  int n_fail  = 0;
  int n_wrap  = 0;
  int tp      = 1;
  logic [31:0] v;

  always #10 clk = ~clk;

  kwdt_top #(.CNT_W(CNT_W), .PEND_CYC(PEND_CYC), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst(rst), .tick_i(tick), .bus_addr(addr),
    .bus_wdata(wdata), .bus_we(we), .bus_rdata(rdata), .rst_req_o(rst_req));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); addr = ADDR_W'(a); wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
    repeat (PEND_CYC + 1) @(negedge clk);
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); addr = ADDR_W'(a);
    @(negedge clk); d = rdata;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    if (rst_req) n_wrap++;
  endtask

  task automatic run_on();
    wr(5, 32'h0000_BBBB); wr(5, 32'h0000_4444);
  endtask

  task automatic run_off();
    wr(5, 32'h0000_AAAA); wr(5, 32'h0000_5555);
  endtask

  task automatic new_trig();
    tp++; wr(4, tp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 / R12: reset state
    chk(rst_req == 1'b0, "R1 rst_req", rst_req, 0);
    rd(6, v); chk(v == 0, "R1 count", v, 0);
    rd(0, v); chk(v == 0, "R1 ctrl", v, 0);
    rd(2, v); chk(v == 0, "R1 status", v, 0);
    rd(3, v); chk(v == 0, "R1 load", v, 0);
    rd(1, v); chk(v == 0, "R1 syscfg", v, 0);

    // R11
    wr(1, 32'hFFFF_FFFE); rd(1, v); chk(v == 0, "R11 syscfg bit0 clear", v, 0);
    wr(1, 32'h0000_0003); rd(1, v); chk(v == 1, "R11 syscfg bit0 set", v, 1);

    // R5: pending flag sweep over every posted register
    for (int r = 0; r < 4; r++) begin
      int a, b;
      logic [31:0] d;
      case (r)
        0: begin a = 0; b = 0; d = 32'h3C; end
        1: begin a = 3; b = 2; d = 32'h123; end
        2: begin a = 4; b = 3; d = 32'(++tp); end
        default: begin a = 5; b = 4; d = 32'h0; end
      endcase
      @(negedge clk); addr = ADDR_W'(a); wdata = d; we = 1'b1;
      @(negedge clk); we = 1'b0; addr = ADDR_W'(2);
      for (int c = 0; c < PEND_CYC; c++) begin
        @(negedge clk);
        chk(rdata == (32'd1 << b), "R5 pending set", rdata, 32'd1 << b);
      end
      @(negedge clk);
      chk(rdata == 0, "R5 pending cleared", rdata, 0);
    end
    rd(0, v); chk(v == 32'h3C, "R5 ctrl committed", v, 32'h3C);
    rd(3, v); chk(v == 32'h123, "R5 load committed", v, 32'h123);

    // R7 / R8 / R2
    wr(0, 0);
    wr(3, 32'h100);
    new_trig();
    rd(6, v); chk(v == 32'h100, "R7 reload on new trigger", v, 32'h100);
    repeat (2) do_tick();
    rd(6, v); chk(v == 32'h100, "R8 stopped holds", v, 32'h100);
    run_on();
    repeat (10) do_tick();
    rd(6, v); chk(v == 32'h10A, "R2 R8 counted up", v, 32'h10A);
    wr(4, tp);
    rd(6, v); chk(v == 32'h10A, "R7 same trigger ignored", v, 32'h10A);
    new_trig();
    rd(6, v); chk(v == 32'h100, "R7 differing trigger reloads", v, 32'h100);

    // R10
    @(negedge clk); addr = 3'd0; wdata = 32'h3C; we = 1'b1;
    @(negedge clk); we = 1'b0; addr = 3'd2;
    @(negedge clk); chk(rdata[0] == 1'b0, "R10 no ctrl pending", rdata, 0);
    rd(0, v); chk(v == 0, "R10 ctrl unchanged", v, 0);
    wr(3, 32'h200);
    rd(3, v); chk(v == 32'h100, "R10 load unchanged", v, 32'h100);

    // R4 broken stop sequence
    wr(5, 32'hAAAA); wr(5, 32'h1234); wr(5, 32'h5555);
    do_tick();
    rd(6, v); chk(v == 32'h101, "R4 broken stop keeps running", v, 32'h101);
    // R3
    run_off();
    repeat (3) do_tick();
    rd(6, v); chk(v == 32'h101, "R3 stopped", v, 32'h101);
    // R4 broken start sequence
    wr(5, 32'hBBBB); wr(5, 32'h1234); wr(5, 32'h4444);
    do_tick();
    rd(6, v); chk(v == 32'h101, "R4 broken start stays stopped", v, 32'h101);

    // R9: wrap sweep, prescaler off
    for (int k = 0; k < 16; k++) begin
      wr(3, MAXV - k);
      new_trig();
      run_on();
      n_wrap = 0;
      for (int t = 0; t < k; t++) do_tick();
      chk(n_wrap == 0, "R9 no early wrap", n_wrap, 0);
      do_tick();
      chk(n_wrap == 1, "R9 wrap on expected tick", n_wrap, 1);
      @(negedge clk);
      chk(rst_req == 1'b0, "R9 one-cycle pulse", rst_req, 0);
      rd(6, v); chk(v == 32'(MAXV - k), "R9 reload after wrap", v, MAXV - k);
      run_off();
    end

    // R6: prescaler sweep
    for (int p = 0; p < 9; p++) begin
      int ticks;
      bit en;
      en = (p < 8);
      ticks = en ? (4 << p) : 4;
      wr(0, (32'(en) << 5) | (32'(p % 8) << 2));
      wr(3, MAXV - 3);
      new_trig();
      run_on();
      n_wrap = 0;
      for (int t = 0; t < ticks - 1; t++) do_tick();
      chk(n_wrap == 0, "R6 no wrap before prescaled count", n_wrap, 0);
      do_tick();
      chk(n_wrap == 1, "R6 wrap at prescaled count", n_wrap, 1);
      run_off();
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule